// File: doc/BRIEF.md
# Compare Match Interval Timer

This block is a periodic interrupt source. A free-running prescaler divides the single peripheral clock. Software picks one of four fixed division ratios. The selected tick advances a 16-bit up-counter while the run bit is set. When the counter reaches the programmed compare value on a tick, it returns to zero in that same tick and a sticky match flag is raised. When the interrupt enable is also set, the flag drives an interrupt request line.

Software reaches the block through a small word-wide register port with three addresses. Address 0 is control. Address 1 is the counter, which is fully readable and writable. Address 2 is the compare value. The block has three ways of starting over. A power-on reset returns everything to its initial state. A manual reset keeps the counter and all settings, and only restarts the prescaler. A standby level holds the counter at zero and keeps the settings.

Top module: `cmit_timer`

## Requirements
- R1: After power-on reset the control register (address 0) reads 0x0000, the counter (address 1) reads 0x0000, the compare register (address 2) reads 0xFFFF, and both `match_flag` and `irq` are low. Control layout: bit 0 run, bits 2:1 clock select, bit 3 interrupt enable, bit 4 match flag.
- R2: The clock select value sets the prescaled tick period in peripheral clocks: 00 gives 8, 01 gives 32, 10 gives 128 and 11 gives 512.
- R3: The counter goes up by one on each tick while run is 1. While run is 0 it keeps its value. Changing the clock select does not alter the counter.
- R4: On a tick where the counter equals the compare value, the counter becomes 0x0000 and the match flag is set. The flag therefore sets every (compare+1) × period clocks, and a compare value of 0 sets it on every tick.
- R5: `irq` is high exactly when the match flag and the interrupt enable are both 1.
- R6: Software clears the flag in two steps. It first reads control while the flag is 1, then writes control with bit 4 at 0. A write without that prior read does not clear the flag, and writing bit 4 as 1 never sets it. If a match and a clear fall in the same cycle, the flag stays set.
- R7: A software write to the counter takes priority over an increment in the same cycle.
- R8: A manual reset leaves the counter, the compare value and the control settings unchanged, and restarts the prescaler.
- R9: While `standby` is high the counter is forced to 0x0000. The control and compare settings are kept.
- R10: A power-on reset in the middle of operation restores every value listed in R1.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| standby | input | 1 | Standby level, holds the counter at zero |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address (0 control, 1 counter, 2 compare) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| match_flag | output | 1 | Sticky compare match flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures the spacing between successive flag rises for several combinations of clock select and compare value. This includes the compare value 0, which sets the flag on every tick. A tap that is off by one bit, or a match that clears one tick late, shows up as a wrong interval. A counter write is repeated at every prescaler phase, so a design that lets the increment win returns the written value plus one. The flag clear sequence is tried without the arming read and with bit 4 written as 1, so a design that clears or sets the flag on a plain write is caught. Manual reset and standby are applied over known register contents: a block that wipes its settings on manual reset, or lets the counter survive standby, reads back the wrong values.

// File: rtl/cmit_pkg.sv
package cmit_pkg;
  localparam int SEL_W        = 2;
  localparam int DIV_BASE_LOG = 3;
  localparam int DIV_STEP_LOG = 2;
  localparam int PRE_W        = DIV_BASE_LOG + DIV_STEP_LOG * ((1 << SEL_W) - 1);

  localparam int CTRL_RUN    = 0;
  localparam int CTRL_SEL_LO = 1;
  localparam int CTRL_IE     = CTRL_SEL_LO + SEL_W;
  localparam int CTRL_FLAG   = CTRL_IE + 1;
  localparam int CTRL_BITS   = CTRL_FLAG + 1;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_CMP   = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;

  // Low prescaler bits that must all be 1 for a tick of the given select.
  function automatic logic [PRE_W-1:0] tap_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W:0] bit_at;
    bit_at = '0;
    bit_at[DIV_BASE_LOG + DIV_STEP_LOG * int'(sel)] = 1'b1;
    return PRE_W'(bit_at - 1'b1);
  endfunction

  // Counter successor on an enabled tick.
  function automatic logic [15:0] step_count(input logic [15:0] cur, input logic [15:0] lim);
    return (cur == lim) ? 16'h0000 : cur + 16'h0001;
  endfunction
endpackage

// File: rtl/cmit_prescaler.sv
module cmit_prescaler
  import cmit_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] phase;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       phase <= '0;
    else if (restart) phase <= '0;
    else              phase <= phase + 1'b1;
  end

  always_comb begin
    mask = tap_mask(sel);
    tick = &(phase | ~mask);
  end

  // R2: a tick is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
    tick |=> !tick);
  // R8: a restart puts the prescaler back at the start of a period
  a_r8_restart_phase: assert property (@(posedge clk) disable iff (!por_n)
    restart |=> !tick);
endmodule

// File: rtl/cmit_counter.sv
module cmit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             standby,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] count,
  output logic             hit
);
  logic advance;

  always_comb begin
    advance = tick && run && !standby && !load;
    hit     = advance && (count == cmp);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       count <= '0;
    else if (standby) count <= '0;
    else if (load)    count <= load_val;
    else if (advance) count <= hit ? '0 : count + 1'b1;
  end

  // R3: stopped counter holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!por_n)
    (!run && !load && !standby) |=> $stable(count));
  // R9: standby forces zero
  a_r9_standby_zero: assert property (@(posedge clk) disable iff (!por_n)
    standby |=> (count == '0));
  // R7: software load wins
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!por_n)
    (load && !standby) |=> (count == $past(load_val)));
  // R4: counter is zero after a match
  a_r4_clear_on_hit: assert property (@(posedge clk) disable iff (!por_n)
    hit |=> (count == '0));
endmodule

// File: rtl/cmit_ctrl.sv
module cmit_ctrl
  import cmit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             man_rst,
  input  logic             ctrl_we,
  input  logic             ctrl_rd,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             hit,
  output logic             run,
  output logic [SEL_W-1:0] sel,
  output logic             ie,
  output logic             flag,
  output logic [CNT_W-1:0] cmp,
  output logic             irq
);
  logic armed;
  logic sw_clear;

  always_comb begin
    sw_clear = ctrl_we && armed && !wdata[CTRL_FLAG];
    irq      = flag && ie;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run <= 1'b0;
      sel <= '0;
      ie  <= 1'b0;
      cmp <= '1;
    end else begin
      if (ctrl_we) begin
        run <= wdata[CTRL_RUN];
        sel <= wdata[CTRL_SEL_LO +: SEL_W];
        ie  <= wdata[CTRL_IE];
      end
      if (cmp_we) cmp <= wdata;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        flag <= 1'b0;
    else if (hit)      flag <= 1'b1;
    else if (sw_clear) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                armed <= 1'b0;
    else if (man_rst)          armed <= 1'b0;
    else if (ctrl_rd && flag)  armed <= 1'b1;
    else if (ctrl_we)          armed <= 1'b0;
  end

  // R4: a match always leaves the flag set (also covers set-wins, R6)
  a_r4_flag_on_hit: assert property (@(posedge clk) disable iff (!por_n)
    hit |=> flag);
  // R6: software writes never set the flag
  a_r6_no_sw_set: assert property (@(posedge clk) disable iff (!por_n)
    (!flag && !hit) |=> !flag);
  // R6: no clear without the arming read
  a_r6_needs_arm: assert property (@(posedge clk) disable iff (!por_n)
    (flag && !armed) |=> flag);
  // R8: manual reset keeps the compare value
  a_r8_keep_cmp: assert property (@(posedge clk) disable iff (!por_n)
    (man_rst && !cmp_we) |=> $stable(cmp));
  // R5: request only with a pending flag
  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!por_n)
    irq |-> flag);
endmodule

// File: rtl/cmit_timer.sv
module cmit_timer
  import cmit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             man_rst,
  input  logic             standby,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             match_flag,
  output logic             irq
);
  reg_addr_e        addr;
  logic             ctrl_we, ctrl_rd, cnt_we, cmp_we;
  logic             tick, hit, run, ie, flag;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] count, cmp;
  logic [CTRL_BITS-1:0] ctrl_view;

  always_comb begin
    addr    = reg_addr_e'(bus_addr);
    ctrl_we = bus_wr && (addr == ADDR_CTRL);
    ctrl_rd = bus_rd && (addr == ADDR_CTRL);
    cnt_we  = bus_wr && (addr == ADDR_COUNT);
    cmp_we  = bus_wr && (addr == ADDR_CMP);
    ctrl_view = {flag, ie, sel, run};
    case (addr)
      ADDR_CTRL:  bus_rdata = CNT_W'(ctrl_view);
      ADDR_COUNT: bus_rdata = count;
      ADDR_CMP:   bus_rdata = cmp;
      default:    bus_rdata = '0;
    endcase
  end

  cmit_prescaler u_pre (
    .clk     (clk),
    .por_n   (por_n),
    .restart (man_rst || standby),
    .sel     (sel),
    .tick    (tick)
  );

  cmit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .por_n    (por_n),
    .standby  (standby),
    .tick     (tick),
    .run      (run),
    .load     (cnt_we),
    .load_val (bus_wdata),
    .cmp      (cmp),
    .count    (count),
    .hit      (hit)
  );

  cmit_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .por_n   (por_n),
    .man_rst (man_rst),
    .ctrl_we (ctrl_we),
    .ctrl_rd (ctrl_rd),
    .cmp_we  (cmp_we),
    .wdata   (bus_wdata),
    .hit     (hit),
    .run     (run),
    .sel     (sel),
    .ie      (ie),
    .flag    (flag),
    .cmp     (cmp),
    .irq     (irq)
  );

  assign match_flag = flag;

  // R8: manual reset keeps the counter when nothing else touches it
  a_r8_keep_count: assert property (@(posedge clk) disable iff (!por_n)
    (man_rst && !standby && !cnt_we && !run) |=> $stable(count));
endmodule

// File: tb/cmit_timer_test.sv
module cmit_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        man_rst = 1'b0;
  logic        standby = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        match_flag, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int exp_q[$];

  cmit_timer uut (
    .clk(clk), .por_n(por_n), .man_rst(man_rst), .standby(standby),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .match_flag(match_flag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All bus tasks start and end at a falling edge.
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic clear_flag();
    logic [15:0] v;
    rd(2'd0, v);
    wr(2'd0, v & ~16'h0010);
  endtask

  // Monitor: pops expected rise-to-rise spacing; -1 marks an unmeasured rise.
  logic prev_flag = 1'b0;
  int last_rise = 0;
  always @(negedge clk) begin
    if (match_flag && !prev_flag) begin
      if (exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        if (e >= 0) check("R2/R4 flag interval", cyc - last_rise, e);
      end
      last_rise = cyc;
    end
    prev_flag = match_flag;
  end

  // Driver: configure, push expectations, service the flag.
  task automatic run_interval(input int sel, input int cmpv, input int n);
    wr(2'd0, 16'h0000);
    if (match_flag) clear_flag();
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'(cmpv));
    exp_q.push_back(-1);
    for (int i = 0; i < n; i++) exp_q.push_back((cmpv + 1) * (8 << (2 * sel)));
    wr(2'd0, 16'(1 | (sel << 1)));
    for (int i = 0; i <= n; i++) begin
      while (!match_flag) @(negedge clk);
      clear_flag();
    end
    wr(2'd0, 16'h0000);
    check("R4 all intervals seen", exp_q.size(), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); check("R1 count", v, 16'h0000);
    rd(2'd2, v); check("R1 compare", v, 16'hFFFF);
    check("R1 flag", match_flag, 0);
    check("R1 irq", irq, 0);

    // R3 exact count over an 80-cycle run window at divide-by-8
    wr(2'd0, 16'h0001);
    repeat (79) @(negedge clk);
    wr(2'd0, 16'h0000);
    rd(2'd1, v); check("R3 counted ticks", v, 10);
    repeat (50) @(negedge clk);
    rd(2'd1, v); check("R3 stopped hold", v, 10);
    wr(2'd0, 16'h0006);
    rd(2'd1, v); check("R3 select change keeps count", v, 10);

    // R2/R4 interval per select and compare value
    run_interval(0, 3, 3);
    run_interval(1, 1, 3);
    run_interval(2, 2, 2);
    run_interval(3, 0, 2);
    run_interval(0, 0, 4);

    // R7 write beats increment, at every prescaler phase
    wr(2'd2, 16'hFFFF);
    wr(2'd0, 16'h0001);
    for (int t = 0; t < 9; t++) begin
      wr(2'd1, 16'h0100);
      bus_addr = 2'd1;
      #1 check("R7 write priority", bus_rdata, 16'h0100);
      @(negedge clk);
      @(negedge clk);
    end
    wr(2'd0, 16'h0000);

    // R5 / R6 interrupt and flag clearing
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0009);
    while (!match_flag) @(negedge clk);
    check("R5 irq with enable", irq, 1);
    wr(2'd0, 16'h0010);
    check("R5 irq masked", irq, 0);
    check("R5 flag still set", match_flag, 1);
    wr(2'd0, 16'h0000);
    check("R6 no clear without read", match_flag, 1);
    rd(2'd0, v); check("R6 flag visible", v, 16'h0010);
    wr(2'd0, 16'h0000);
    check("R6 clear after read", match_flag, 0);
    wr(2'd0, 16'h0010);
    check("R6 write one ignored", match_flag, 0);

    // R8 manual reset keeps state
    wr(2'd1, 16'h0055);
    wr(2'd2, 16'h0777);
    wr(2'd0, 16'h000C);
    man_rst = 1'b1; @(negedge clk); man_rst = 1'b0;
    rd(2'd1, v); check("R8 count kept", v, 16'h0055);
    rd(2'd2, v); check("R8 compare kept", v, 16'h0777);
    rd(2'd0, v); check("R8 ctrl kept", v, 16'h000C);

    // R9 standby zeros the counter only
    standby = 1'b1; @(negedge clk); standby = 1'b0;
    rd(2'd1, v); check("R9 count zeroed", v, 16'h0000);
    rd(2'd2, v); check("R9 compare kept", v, 16'h0777);
    rd(2'd0, v); check("R9 ctrl kept", v, 16'h000C);

    // R10 power-on reset mid-run
    wr(2'd1, 16'h1234);
    wr(2'd0, 16'h000F);
    repeat (20) @(negedge clk);
    por_n = 1'b0; @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R10 ctrl", v, 16'h0000);
    rd(2'd1, v); check("R10 count", v, 16'h0000);
    rd(2'd2, v); check("R10 compare", v, 16'hFFFF);
    check("R10 irq", irq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule